// File: doc/BRIEF.md
# Streaming Pixel Colour Space Converter

This block converts three-component pixels for one display source pipe. Each pixel arrives on a valid/ready input stream, optionally passes through a per-component offset-and-limit step, a signed 3x3 matrix, and a second offset-and-limit step, and leaves on a matching valid/ready output stream together with a sideband tag that travels alongside it unchanged. With conversion switched off, the pixel reaches the output bit for bit as it came in, on the same three-cycle schedule.

Software loads the settings through a simple write port: nine matrix weights, a signed offset for each component before and after the matrix, a low/high limit pair for each component before and after the matrix, an on/off bit and two flags saying whether the incoming and outgoing pixels are YUV. Writes land in a staging copy. The copy that drives the datapath is refreshed only on a frame-start strobe, so every pixel of a frame uses one consistent setting. The strobe is meant to be issued in blanking, while no pixel is inside the block.

Back-pressure rules: an input pixel is taken on a clock edge where `s_valid` and `s_ready` are both high. The three pipeline stages advance together, and they advance only when the output register is empty or `m_ready` is high, so `s_ready` falls exactly when a held output is not being taken. While `m_valid` is high and `m_ready` is low, `m_pix`, `m_side` and `m_yuv` do not change.

Top module: `pipe_csc_top`

## Requirements
- R1: After reset `m_valid` is 0 and `s_ready` is 1; the settings reset to conversion off, both YUV flags 0, diagonal weights 1.0 (512) and all others 0, all offsets 0, every low limit 0 and every high limit 255, so enabling conversion without other writes reproduces the input.
- R2: With the on/off bit clear (control word, address 0, bit 0), `m_pix` equals the accepted input pixel exactly.
- R3: Every accepted pixel appears at the output three register stages later when not stalled, in acceptance order, with its `s_side` value; at most three pixels are inside the block.
- R4: While `m_valid` is high and `m_ready` low, the outputs hold and no input is accepted.
- R5: Configuration writes do not affect conversion until a `frame_start` pulse, after which all of them apply together.
- R6: Matrix weights are signed 13-bit with 9 fractional bits, stored in words at addresses 1 to 5: weight order 11,12,13,21,22,23,31,32,33, two per word, the earlier weight in bits 12:0 and the later in bits 28:16, with weight 33 alone in bits 12:0 of address 5. Output component r is weight r1 times component 0, plus r2 times component 1, plus r3 times component 2 (component 0 in bits 7:0, 1 in 15:8, 2 in 23:16).
- R7: Before the matrix, each component gets its own signed 9-bit offset (address 12+c, bits 8:0) added and is then limited by its own pair (address 6+c, low in bits 7:0, high in bits 15:8): below the low limit gives the low limit, otherwise above the high limit gives the high limit.
- R8: The matrix sum is rounded by adding 256 and shifting right arithmetically by 9 (halves round upward, also for negative sums).
- R9: After rounding, each component gets its own signed 9-bit offset (address 15+c) added and is then limited by its own pair (address 9+c) with the same rule as R7.
- R10: `m_yuv` reports the output pixel format: the destination flag (control bit 2) when conversion is on, otherwise the source flag (control bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| frame_start | input | 1 | Copies staged settings into the working copy |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high with s_valid |
| s_pix | input | 24 | Input pixel, three 8-bit components |
| s_side | input | 2 | Sideband tag carried with the pixel |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream accepts the output pixel |
| m_pix | output | 24 | Output pixel |
| m_side | output | 2 | Sideband tag of the output pixel |
| m_yuv | output | 1 | Output pixel is YUV |

## Verification
The bench loads a matrix with a single non-zero weight in each of the nine positions in turn, so a design that packed weights into the wrong half or the wrong word, or multiplied the transposed matrix, puts the result in the wrong component. It sends extreme pixels through YUV-like offsets and limits, a crossed limit pair and negative half-way sums, which a design with the wrong clamp priority, a missing sign extension or truncating rounding gets wrong by one or more codes. It writes new settings without a strobe and keeps sending pixels, catching a design that applies writes at once, and it throttles `m_ready` while streaming tagged pixels, catching lost, repeated or reordered pixels and sidebands that drift from their pixel.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int NCOMP  = 3;
  localparam int NCOEF  = NCOMP * NCOMP;
  localparam int CFG_AW = 5;
  localparam int CFG_DW = 32;
  localparam int HI_LANE = 16;

  // Word addresses of the configuration space
  localparam logic [CFG_AW-1:0] A_CTRL       = 5'd0;
  localparam logic [CFG_AW-1:0] A_COEF       = 5'd1;
  localparam logic [CFG_AW-1:0] A_PRE_CLAMP  = 5'd6;
  localparam logic [CFG_AW-1:0] A_POST_CLAMP = 5'd9;
  localparam logic [CFG_AW-1:0] A_PRE_BIAS   = 5'd12;
  localparam logic [CFG_AW-1:0] A_POST_BIAS  = 5'd15;

  // Control word bits
  localparam int CTRL_EN      = 0;
  localparam int CTRL_SRC_YUV = 1;
  localparam int CTRL_DST_YUV = 2;

  // Low limit wins when both limits would apply
  function automatic int clamp_lh(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/csc_cfg_regs.sv
module csc_cfg_regs
  import csc_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CW   = 13,
  parameter int BW   = 9,
  parameter int FRAC = 9
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [CFG_AW-1:0]                 addr,
  input  logic [CFG_DW-1:0]                 wdata,
  input  logic                              frame_start,
  output logic                              act_en,
  output logic                              act_src_yuv,
  output logic                              act_dst_yuv,
  output logic [NCOEF-1:0][CW-1:0]          act_coef,
  output logic [NCOMP-1:0][BW-1:0]          act_pre_bias,
  output logic [NCOMP-1:0][BW-1:0]          act_post_bias,
  output logic [NCOMP-1:0][DW-1:0]          act_pre_lo,
  output logic [NCOMP-1:0][DW-1:0]          act_pre_hi,
  output logic [NCOMP-1:0][DW-1:0]          act_post_lo,
  output logic [NCOMP-1:0][DW-1:0]          act_post_hi
);
  localparam logic [CW-1:0] UNITY = CW'(1 << FRAC);

  logic                     sh_en, sh_src_yuv, sh_dst_yuv;
  logic [NCOEF-1:0][CW-1:0] sh_coef;
  logic [NCOMP-1:0][BW-1:0] sh_pre_bias, sh_post_bias;
  logic [NCOMP-1:0][DW-1:0] sh_pre_lo, sh_pre_hi, sh_post_lo, sh_post_hi;

  // Staging copy: written by software at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_en      <= 1'b0;
      sh_src_yuv <= 1'b0;
      sh_dst_yuv <= 1'b0;
      for (int i = 0; i < NCOEF; i++)
        sh_coef[i] <= (i % (NCOMP + 1) == 0) ? UNITY : '0;
      for (int c = 0; c < NCOMP; c++) begin
        sh_pre_bias[c]  <= '0;
        sh_post_bias[c] <= '0;
        sh_pre_lo[c]    <= '0;
        sh_pre_hi[c]    <= '1;
        sh_post_lo[c]   <= '0;
        sh_post_hi[c]   <= '1;
      end
    end else if (we) begin
      if (addr == A_CTRL) begin
        sh_en      <= wdata[CTRL_EN];
        sh_src_yuv <= wdata[CTRL_SRC_YUV];
        sh_dst_yuv <= wdata[CTRL_DST_YUV];
      end
      for (int i = 0; i < NCOEF; i++)
        if (addr == A_COEF + CFG_AW'(i / 2))
          sh_coef[i] <= (i % 2 == 0) ? wdata[CW-1:0] : wdata[HI_LANE +: CW];
      for (int c = 0; c < NCOMP; c++) begin
        if (addr == A_PRE_CLAMP + CFG_AW'(c)) begin
          sh_pre_lo[c] <= wdata[DW-1:0];
          sh_pre_hi[c] <= wdata[DW +: DW];
        end
        if (addr == A_POST_CLAMP + CFG_AW'(c)) begin
          sh_post_lo[c] <= wdata[DW-1:0];
          sh_post_hi[c] <= wdata[DW +: DW];
        end
        if (addr == A_PRE_BIAS + CFG_AW'(c))
          sh_pre_bias[c] <= wdata[BW-1:0];
        if (addr == A_POST_BIAS + CFG_AW'(c))
          sh_post_bias[c] <= wdata[BW-1:0];
      end
    end
  end

  // Working copy: refreshed only at frame start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en      <= 1'b0;
      act_src_yuv <= 1'b0;
      act_dst_yuv <= 1'b0;
      for (int i = 0; i < NCOEF; i++)
        act_coef[i] <= (i % (NCOMP + 1) == 0) ? UNITY : '0;
      for (int c = 0; c < NCOMP; c++) begin
        act_pre_bias[c]  <= '0;
        act_post_bias[c] <= '0;
        act_pre_lo[c]    <= '0;
        act_pre_hi[c]    <= '1;
        act_post_lo[c]   <= '0;
        act_post_hi[c]   <= '1;
      end
    end else if (frame_start) begin
      act_en        <= sh_en;
      act_src_yuv   <= sh_src_yuv;
      act_dst_yuv   <= sh_dst_yuv;
      act_coef      <= sh_coef;
      act_pre_bias  <= sh_pre_bias;
      act_post_bias <= sh_post_bias;
      act_pre_lo    <= sh_pre_lo;
      act_pre_hi    <= sh_pre_hi;
      act_post_lo   <= sh_post_lo;
      act_post_hi   <= sh_post_hi;
    end
  end
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
  import csc_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CW   = 13,
  parameter int BW   = 9,
  parameter int FRAC = 9,
  parameter int SBW  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     in_valid,
  input  logic [NCOMP*DW-1:0]      in_pix,
  input  logic [SBW-1:0]           in_side,
  input  logic                     en,
  input  logic                     src_yuv,
  input  logic                     dst_yuv,
  input  logic [NCOEF-1:0][CW-1:0] coef,
  input  logic [NCOMP-1:0][BW-1:0] pre_bias,
  input  logic [NCOMP-1:0][BW-1:0] post_bias,
  input  logic [NCOMP-1:0][DW-1:0] pre_lo,
  input  logic [NCOMP-1:0][DW-1:0] pre_hi,
  input  logic [NCOMP-1:0][DW-1:0] post_lo,
  input  logic [NCOMP-1:0][DW-1:0] post_hi,
  output logic                     out_valid,
  output logic [NCOMP*DW-1:0]      out_pix,
  output logic [SBW-1:0]           out_side,
  output logic                     out_yuv
);
  localparam int PW   = NCOMP * DW;
  localparam int ACCW = CW + DW + 3;
  localparam int HALF = 1 << (FRAC - 1);

  logic                   v1, v2;
  logic [SBW-1:0]         sd1, sd2;
  logic [PW-1:0]          raw1, raw2;
  logic [DW-1:0]          x_nxt [NCOMP];
  logic [DW-1:0]          x1    [NCOMP];
  logic signed [31:0]     sum_w [NCOMP];
  logic signed [ACCW-1:0] acc2  [NCOMP];
  logic [DW-1:0]          y_nxt [NCOMP];

  // Stage 1 input: offset then limit, per component
  always_comb begin
    for (int c = 0; c < NCOMP; c++)
      x_nxt[c] = DW'(clamp_lh(int'({1'b0, in_pix[c*DW +: DW]}) + int'(signed'(pre_bias[c])),
                              int'({1'b0, pre_lo[c]}), int'({1'b0, pre_hi[c]})));
  end

  // Stage 2 input: row-by-column products summed
  always_comb begin
    for (int r = 0; r < NCOMP; r++) begin
      sum_w[r] = '0;
      for (int j = 0; j < NCOMP; j++)
        sum_w[r] = sum_w[r] + int'(signed'(coef[r*NCOMP + j])) * int'({1'b0, x1[j]});
    end
  end

  // Stage 3 input: round, offset, limit
  always_comb begin
    for (int r = 0; r < NCOMP; r++)
      y_nxt[r] = DW'(clamp_lh(((int'(acc2[r]) + HALF) >>> FRAC) + int'(signed'(post_bias[r])),
                              int'({1'b0, post_lo[r]}), int'({1'b0, post_hi[r]})));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
      sd1       <= '0;
      sd2       <= '0;
      raw1      <= '0;
      raw2      <= '0;
      out_side  <= '0;
      out_pix   <= '0;
      out_yuv   <= 1'b0;
      for (int c = 0; c < NCOMP; c++) begin
        x1[c]   <= '0;
        acc2[c] <= '0;
      end
    end else if (adv) begin
      v1        <= in_valid;
      v2        <= v1;
      out_valid <= v2;
      sd1       <= in_side;
      sd2       <= sd1;
      out_side  <= sd2;
      raw1      <= in_pix;
      raw2      <= raw1;
      out_yuv   <= en ? dst_yuv : src_yuv;
      for (int c = 0; c < NCOMP; c++) begin
        x1[c]                <= x_nxt[c];
        acc2[c]              <= ACCW'(sum_w[c]);
        out_pix[c*DW +: DW]  <= en ? y_nxt[c] : raw2[c*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/pipe_csc_top.sv
module pipe_csc_top
  import csc_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CW   = 13,
  parameter int BW   = 9,
  parameter int FRAC = 9,
  parameter int SBW  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [CFG_DW-1:0]     cfg_wdata,
  input  logic                  frame_start,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [NCOMP*DW-1:0]   s_pix,
  input  logic [SBW-1:0]        s_side,
  output logic                  m_valid,
  input  logic                  m_ready,
  output logic [NCOMP*DW-1:0]   m_pix,
  output logic [SBW-1:0]        m_side,
  output logic                  m_yuv
);
  logic                     act_en, act_src_yuv, act_dst_yuv;
  logic [NCOEF-1:0][CW-1:0] act_coef;
  logic [NCOMP-1:0][BW-1:0] act_pre_bias, act_post_bias;
  logic [NCOMP-1:0][DW-1:0] act_pre_lo, act_pre_hi, act_post_lo, act_post_hi;
  logic                     adv;

  // All stages move together; they move when the output slot frees up
  assign adv     = m_ready || !m_valid;
  assign s_ready = adv;

  csc_cfg_regs #(.DW(DW), .CW(CW), .BW(BW), .FRAC(FRAC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .frame_start(frame_start),
    .act_en(act_en), .act_src_yuv(act_src_yuv), .act_dst_yuv(act_dst_yuv),
    .act_coef(act_coef), .act_pre_bias(act_pre_bias), .act_post_bias(act_post_bias),
    .act_pre_lo(act_pre_lo), .act_pre_hi(act_pre_hi),
    .act_post_lo(act_post_lo), .act_post_hi(act_post_hi)
  );

  csc_datapath #(.DW(DW), .CW(CW), .BW(BW), .FRAC(FRAC), .SBW(SBW)) u_dp (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .in_valid(s_valid), .in_pix(s_pix), .in_side(s_side),
    .en(act_en), .src_yuv(act_src_yuv), .dst_yuv(act_dst_yuv),
    .coef(act_coef), .pre_bias(act_pre_bias), .post_bias(act_post_bias),
    .pre_lo(act_pre_lo), .pre_hi(act_pre_hi), .post_lo(act_post_lo), .post_hi(act_post_hi),
    .out_valid(m_valid), .out_pix(m_pix), .out_side(m_side), .out_yuv(m_yuv)
  );
endmodule

// File: rtl/csc_checker.sv
module csc_checker
  import csc_pkg::*;
#(
  parameter int DW  = 8,
  parameter int CW  = 13,
  parameter int SBW = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  s_valid,
  input logic                  s_ready,
  input logic                  m_valid,
  input logic                  m_ready,
  input logic [NCOMP*DW-1:0]   m_pix,
  input logic [SBW-1:0]        m_side,
  input logic                  frame_start,
  input logic                  act_en,
  input logic [NCOEF*CW-1:0]   act_coef_flat,
  input logic [NCOMP*DW-1:0]   act_post_lo_flat,
  input logic [NCOMP*DW-1:0]   act_post_hi_flat
);
  logic [2:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 3'(s_valid && s_ready) - 3'(m_valid && m_ready);
  end

  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_pix) && $stable(m_side)));

  assert_no_intake_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  assert_depth_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 3'd3);

  assert_output_has_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (inflight != 3'd0));

  assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(act_coef_flat) && $stable(act_en)
                      && $stable(act_post_lo_flat) && $stable(act_post_hi_flat)));

  for (genvar c = 0; c < NCOMP; c++) begin : g_range
    assert_post_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && act_en && (act_post_lo_flat[c*DW +: DW] <= act_post_hi_flat[c*DW +: DW]))
      |-> (m_pix[c*DW +: DW] >= act_post_lo_flat[c*DW +: DW]
           && m_pix[c*DW +: DW] <= act_post_hi_flat[c*DW +: DW]));
  end
endmodule

bind pipe_csc_top csc_checker #(.DW(DW), .CW(CW), .SBW(SBW)) chk_i (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_pix(m_pix), .m_side(m_side),
  .frame_start(frame_start), .act_en(act_en), .act_coef_flat(act_coef),
  .act_post_lo_flat(act_post_lo), .act_post_hi_flat(act_post_hi)
);

// File: tb/pipe_csc_top_tb_top.sv
`timescale 1ns/1ps
module pipe_csc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        frame_start = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [23:0] s_pix = '0;
  logic [1:0]  s_side = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [23:0] m_pix;
  logic [1:0]  m_side;
  logic        m_yuv;

  always #2 clk = ~clk;

  pipe_csc_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .frame_start(frame_start), .s_valid(s_valid), .s_ready(s_ready), .s_pix(s_pix),
    .s_side(s_side), .m_valid(m_valid), .m_ready(m_ready), .m_pix(m_pix),
    .m_side(m_side), .m_yuv(m_yuv)
  );

  typedef struct {
    logic [23:0] pix;
    logic [1:0]  side;
    logic        yuv;
    string       tag;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model of staged and working settings
  bit sh_en, sh_sy, sh_dy, ac_en, ac_sy, ac_dy;
  int sh_coef[9], ac_coef[9];
  int sh_prb[3], sh_pob[3], sh_plo[3], sh_phi[3], sh_qlo[3], sh_qhi[3];
  int ac_prb[3], ac_pob[3], ac_plo[3], ac_phi[3], ac_qlo[3], ac_qhi[3];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int lim(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [23:0] model(input logic [23:0] p);
    int x[3];
    int acc, y;
    logic [23:0] o;
    if (!ac_en) return p;
    for (int c = 0; c < 3; c++) x[c] = lim(int'(p[c*8 +: 8]) + ac_prb[c], ac_plo[c], ac_phi[c]);
    for (int r = 0; r < 3; r++) begin
      acc = 0;
      for (int j = 0; j < 3; j++) acc = acc + ac_coef[r*3 + j] * x[j];
      y = lim(((acc + 256) >>> 9) + ac_pob[r], ac_qlo[r], ac_qhi[r]);
      o[r*8 +: 8] = y[7:0];
    end
    return o;
  endfunction

  task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic set_ctrl(input bit en, input bit sy, input bit dy);
    sh_en = en; sh_sy = sy; sh_dy = dy;
    cfg_write(5'd0, {29'b0, dy, sy, en});
  endtask

  task automatic push_coefs();
    for (int w = 0; w < 5; w++) begin
      int hi;
      hi = (2*w + 1 < 9) ? sh_coef[2*w + 1] : 0;
      cfg_write(5'(1 + w), {3'b0, 13'(hi), 3'b0, 13'(sh_coef[2*w])});
    end
  endtask

  task automatic set_clamp(input bit post, input int c, input int lo, input int hi);
    if (post) begin sh_qlo[c] = lo; sh_qhi[c] = hi; end
    else begin sh_plo[c] = lo; sh_phi[c] = hi; end
    cfg_write(post ? 5'(9 + c) : 5'(6 + c), {16'b0, 8'(hi), 8'(lo)});
  endtask

  task automatic set_bias(input bit post, input int c, input int b);
    if (post) sh_pob[c] = b; else sh_prb[c] = b;
    cfg_write(post ? 5'(15 + c) : 5'(12 + c), {23'b0, 9'(b)});
  endtask

  task automatic frame_pulse();
    while (q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
    frame_start = 1'b1;
    @(posedge clk); #1;
    frame_start = 1'b0;
    ac_en = sh_en; ac_sy = sh_sy; ac_dy = sh_dy;
    ac_coef = sh_coef;
    ac_prb = sh_prb; ac_pob = sh_pob;
    ac_plo = sh_plo; ac_phi = sh_phi; ac_qlo = sh_qlo; ac_qhi = sh_qhi;
  endtask

  task automatic send(input logic [23:0] p, input logic [1:0] sd, input string tag);
    exp_t e;
    s_pix = p; s_side = sd; s_valid = 1'b1;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    e.pix = model(p); e.side = sd; e.yuv = ac_en ? ac_dy : ac_sy; e.tag = tag;
    q.push_back(e);
    @(posedge clk); #1;
    s_valid = 1'b0;
  endtask

  // Scoreboard monitor: compares the item the next edge will consume
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, "R3", "unexpected output", {5'b0, m_yuv, m_side, m_pix}, 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({m_yuv, m_side, m_pix} == {e.yuv, e.side, e.pix}, e.tag, "yuv/side/pix",
            {5'b0, m_yuv, m_side, m_pix}, {5'b0, e.yuv, e.side, e.pix});
      end
    end
  end

  // Downstream readiness: throttled when bp is set
  bit bp = 1'b0;
  int cyc = 0;
  always @(posedge clk) begin
    #1;
    m_ready = bp ? (cyc % 3 != 2) : 1'b1;
    cyc++;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #600000;
    chk(1'b0, "R3", "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    // Model reset values (R1)
    sh_en = 0; sh_sy = 0; sh_dy = 0;
    sh_coef = '{512, 0, 0, 0, 512, 0, 0, 0, 512};
    for (int c = 0; c < 3; c++) begin
      sh_prb[c] = 0; sh_pob[c] = 0; sh_plo[c] = 0; sh_phi[c] = 255; sh_qlo[c] = 0; sh_qhi[c] = 255;
    end
    ac_en = sh_en; ac_sy = sh_sy; ac_dy = sh_dy; ac_coef = sh_coef;
    ac_prb = sh_prb; ac_pob = sh_pob; ac_plo = sh_plo; ac_phi = sh_phi; ac_qlo = sh_qlo; ac_qhi = sh_qhi;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(m_valid == 1'b0, "R1", "m_valid after reset", {31'b0, m_valid}, 32'h0);
    chk(s_ready == 1'b1, "R1", "s_ready after reset", {31'b0, s_ready}, 32'h1);
    @(posedge clk); #1;

    // R2: bypass with reset settings
    send(24'h123456, 2'd1, "R2");
    send(24'hFF00A5, 2'd2, "R2");
    send(24'h000000, 2'd3, "R2");
    send(24'hFFFFFF, 2'd0, "R2");

    // R10: bypass reports the source flag
    set_ctrl(1'b0, 1'b1, 1'b0);
    frame_pulse();
    send(24'h80407F, 2'd1, "R10");

    // R1: enabling with default settings reproduces the input
    set_ctrl(1'b1, 1'b1, 1'b0);
    frame_pulse();
    send(24'h0A1B2C, 2'd0, "R1");
    send(24'hFF0001, 2'd1, "R1");
    send(24'h7F80FE, 2'd2, "R1");

    // R7/R8/R9: YUV-like conversion with extremes
    sh_coef = '{596, 0, 817, 596, -200, -416, 596, 1033, 0};
    push_coefs();
    set_bias(1'b0, 0, -16); set_bias(1'b0, 1, -128); set_bias(1'b0, 2, -128);
    set_clamp(1'b0, 0, 16, 235); set_clamp(1'b0, 1, 16, 240); set_clamp(1'b0, 2, 16, 240);
    frame_pulse();
    send(24'h808010, 2'd0, "R7");
    send(24'h8080EB, 2'd1, "R7");
    send(24'hF05A51, 2'd2, "R8");
    send(24'h000000, 2'd3, "R7");
    send(24'hFFFFFF, 2'd0, "R7");
    send(24'h223691, 2'd1, "R8");
    set_bias(1'b1, 0, 10); set_bias(1'b1, 1, -20); set_bias(1'b1, 2, 5);
    set_clamp(1'b1, 0, 20, 230); set_clamp(1'b1, 1, 20, 230); set_clamp(1'b1, 2, 20, 230);
    frame_pulse();
    send(24'h808010, 2'd2, "R9");
    send(24'h8080EB, 2'd3, "R9");
    send(24'hF05A51, 2'd0, "R9");
    send(24'h10F080, 2'd1, "R9");

    // R5: staged writes do not apply before the strobe
    set_ctrl(1'b1, 1'b1, 1'b1);
    sh_coef = '{0, 512, 0, 0, 0, 512, 512, 0, 0};
    push_coefs();
    set_bias(1'b1, 0, 0);
    send(24'h8080EB, 2'd2, "R5");
    send(24'h30C050, 2'd3, "R5");
    frame_pulse();
    send(24'h8080EB, 2'd0, "R5");
    send(24'h30C050, 2'd1, "R5");

    // R6: one weight at a time reveals packing and orientation
    for (int c = 0; c < 3; c++) begin
      set_bias(1'b0, c, 0); set_bias(1'b1, c, 0);
      set_clamp(1'b0, c, 0, 255); set_clamp(1'b1, c, 0, 255);
    end
    for (int k = 0; k < 9; k++) begin
      for (int i = 0; i < 9; i++) sh_coef[i] = (i == k) ? 512 + 37 * k : 0;
      push_coefs();
      frame_pulse();
      send(24'h3C2814, 2'(k), "R6");
    end

    // R8: negative and positive half-way sums round upward
    sh_coef = '{-256, 0, 0, 0, 256, 0, 0, 0, -768};
    push_coefs();
    set_bias(1'b1, 0, 10); set_bias(1'b1, 1, 0); set_bias(1'b1, 2, 100);
    frame_pulse();
    send(24'h010103, 2'd0, "R8");
    send(24'h030101, 2'd1, "R8");
    send(24'h050305, 2'd2, "R8");

    // R7: crossed limit pair, low limit wins first
    sh_coef = '{512, 0, 0, 0, 512, 0, 0, 0, 512};
    push_coefs();
    for (int c = 0; c < 3; c++) set_bias(1'b1, c, 0);
    set_clamp(1'b0, 0, 200, 100);
    frame_pulse();
    send(24'h000032, 2'd0, "R7");
    send(24'h0000FA, 2'd1, "R7");
    send(24'h0000C8, 2'd2, "R7");

    // R3/R4: streaming under throttled downstream, with YUV-like settings
    sh_coef = '{596, 0, 817, 596, -200, -416, 596, 1033, 0};
    push_coefs();
    set_clamp(1'b0, 0, 16, 235);
    set_bias(1'b0, 0, -16); set_bias(1'b0, 1, -128); set_bias(1'b0, 2, -128);
    frame_pulse();
    bp = 1'b1;
    for (int i = 0; i < 24; i++)
      send(24'(i * 32'h0B1D37 + 32'h102030), 2'(i), (i % 2 == 0) ? "R3" : "R4");
    frame_pulse();
    bp = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk(q.size() == 0, "R3", "items left in scoreboard", 32'(q.size()), 32'h0);
    finish_run();
  end
endmodule